// File: doc/BRIEF.md
# Receive Character Timeout Timer

This block watches a receive FIFO for characters that have been waiting too long without being collected. It counts 16x baud ticks. When the FIFO holds data, nothing new has arrived and the processor has not read the FIFO for four full character times, it raises a timeout-pending flag. Interrupt logic can then tell software to drain the leftover bytes that never reached the trigger level.

A character time is sixteen ticks per bit multiplied by the configured frame length. The frame length counts start, data, parity and all stop bits, including a second stop bit. The timer restarts on every received character and on every FIFO read while the flag is low. Once the flag is up, only a read clears it. The timer stays idle while the FIFO is empty, while the block is disabled, or while the trigger level is one or less.

Top module: `rxto_timer`

## Requirements
- R1: While `rst_n` is low, `timeout_o` is 0.
- R2: `timeout_o` rises on the clock edge that samples the N-th `tick16_i` pulse since the last restart, where N = 64 × frame length (four characters × 16 ticks per bit; 768 for a 12-bit frame). The pulses before that edge leave it low.
- R3: `frame_bits_i` values below 7 act as 7 (N = 448), and values above 12 act as 12 (N = 768).
- R4: A cycle with `fifo_level_i` = 0 drives `timeout_o` to 0 on the next edge and sets the tick count back to zero.
- R5: A cycle with `enable_i` = 0 drives `timeout_o` to 0 on the next edge and sets the tick count back to zero.
- R6: While `trig_level_i` is 0 or 1, `timeout_o` stays 0 and no ticks are counted.
- R7: While `timeout_o` is 0, a `push_i` cycle restarts the tick count from zero.
- R8: While `timeout_o` is 0, a `pop_i` cycle restarts the tick count from zero.
- R9: While `timeout_o` is 1, a `pop_i` cycle clears it on the next edge and restarts the count.
- R10: While `timeout_o` is 1, `push_i` has no effect: the flag stays high until a read.
- R11: A tick in the same cycle as a restart by `push_i` or `pop_i` is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16_i | input | 1 | One-cycle pulse at 16x the baud rate |
| frame_bits_i | input | 4 | Bits per character including all stop bits |
| push_i | input | 1 | A received character entered the FIFO |
| pop_i | input | 1 | The processor read one character from the FIFO |
| fifo_level_i | input | 5 | Characters currently held in the FIFO |
| trig_level_i | input | 5 | Programmed receive trigger level |
| enable_i | input | 1 | Timeout function enable |
| timeout_o | output | 1 | Timeout pending |

## Verification
The hardest case to reach is the exact expiry edge. A flag that rises one tick early or late only shows up after hundreds of uninterrupted ticks, and any stray push or read in that span hides the error. Directed runs therefore drive unbroken streams of ticks, one per cycle, up to N−1 and N for both clamp limits. They also place a restart in the same cycle as a tick. A seeded random phase then varies the tick spacing, the frame length and the qualifiers, with pushes and reads rare enough that expiries still happen often.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_CLEAR   = 2'd1,
    ACT_ADVANCE = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/rxto_rst_sync.sv
module rxto_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/rxto_frame_limit.sv
module rxto_frame_limit #(
  parameter int FRAME_W  = 4,
  parameter int MIN_BITS = 7,
  parameter int MAX_BITS = 12,
  parameter int OVS      = 16,
  parameter int CHARS    = 4,
  parameter int LIM_W    = 10
) (
  input  logic [FRAME_W-1:0] frame_bits_i,
  output logic [LIM_W-1:0]   limit_o
);
  localparam int  SCALE      = OVS * CHARS;
  localparam bit  SCALE_POW2 = ((SCALE & (SCALE - 1)) == 0);
  localparam int  SHIFT      = $clog2(SCALE);

  logic [FRAME_W-1:0] bits_c;

  // Clamp the frame length into the supported range.
  always_comb begin
    if (frame_bits_i < FRAME_W'(MIN_BITS)) begin
      bits_c = FRAME_W'(MIN_BITS);
    end else if (frame_bits_i > FRAME_W'(MAX_BITS)) begin
      bits_c = FRAME_W'(MAX_BITS);
    end else begin
      bits_c = frame_bits_i;
    end
  end

  generate
    if (SCALE_POW2) begin : g_shift
      assign limit_o = LIM_W'(bits_c) << SHIFT;
    end else begin : g_mult
      assign limit_o = LIM_W'(bits_c) * LIM_W'(SCALE);
    end
  endgenerate
endmodule

// File: rtl/rxto_arm_qual.sv
module rxto_arm_qual #(
  parameter int LVL_W = 5
) (
  input  logic             enable_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic [LVL_W-1:0] trig_level_i,
  output logic             armed_o
);
  logic has_data;
  logic trig_ok;

  assign has_data = (fifo_level_i != '0);
  assign trig_ok  = (trig_level_i > LVL_W'(1));
  assign armed_o  = enable_i & has_data & trig_ok;
endmodule

// File: rtl/rxto_tick_counter.sv
module rxto_tick_counter #(
  parameter int LIM_W = 10
) (
  input  logic                clk,
  input  logic                srst_n,
  input  rxto_pkg::cnt_act_e  act_i,
  input  logic [LIM_W-1:0]    limit_i,
  output logic                at_last_o
);
  import rxto_pkg::*;

  logic [LIM_W-1:0] count_q;
  logic [LIM_W-1:0] count_d;

  assign at_last_o = (count_q == (limit_i - LIM_W'(1)));

  always_comb begin
    count_d = count_q;
    unique case (act_i)
      ACT_CLEAR:   count_d = '0;
      ACT_ADVANCE: count_d = at_last_o ? '0 : (count_q + LIM_W'(1));
      default:     count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end
endmodule

// File: rtl/rxto_timer.sv
module rxto_timer #(
  parameter int FRAME_W  = 4,
  parameter int LVL_W    = 5,
  parameter int MIN_BITS = 7,
  parameter int MAX_BITS = 12,
  parameter int OVS      = 16,
  parameter int CHARS    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick16_i,
  input  logic [FRAME_W-1:0] frame_bits_i,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic [LVL_W-1:0]   fifo_level_i,
  input  logic [LVL_W-1:0]   trig_level_i,
  input  logic               enable_i,
  output logic               timeout_o
);
  import rxto_pkg::*;

  localparam int LIM_W = $clog2(OVS * CHARS * MAX_BITS + 1);

  logic             srst_n;
  logic [LIM_W-1:0] limit;
  logic             armed;
  logic             at_last;
  cnt_act_e         act;
  logic             flag_q;
  logic             flag_d;

  rxto_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  rxto_frame_limit #(
    .FRAME_W  (FRAME_W),
    .MIN_BITS (MIN_BITS),
    .MAX_BITS (MAX_BITS),
    .OVS      (OVS),
    .CHARS    (CHARS),
    .LIM_W    (LIM_W)
  ) u_limit (
    .frame_bits_i (frame_bits_i),
    .limit_o      (limit)
  );

  rxto_arm_qual #(
    .LVL_W (LVL_W)
  ) u_arm (
    .enable_i     (enable_i),
    .fifo_level_i (fifo_level_i),
    .trig_level_i (trig_level_i),
    .armed_o      (armed)
  );

  rxto_tick_counter #(
    .LIM_W (LIM_W)
  ) u_cnt (
    .clk       (clk),
    .srst_n    (srst_n),
    .act_i     (act),
    .limit_i   (limit),
    .at_last_o (at_last)
  );

  // Priority: disarm, then pending-flag handling, then restart, then tick.
  always_comb begin
    act    = ACT_HOLD;
    flag_d = flag_q;
    if (!armed) begin
      act    = ACT_CLEAR;
      flag_d = 1'b0;
    end else if (flag_q) begin
      if (pop_i) begin
        act    = ACT_CLEAR;
        flag_d = 1'b0;
      end
    end else if (push_i || pop_i) begin
      act = ACT_CLEAR;
    end else if (tick16_i) begin
      act = ACT_ADVANCE;
      if (at_last) begin
        flag_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign timeout_o = flag_q;
endmodule

// File: rtl/rxto_timer_chk.sv
module rxto_timer_chk #(
  parameter int LVL_W    = 5,
  parameter int LIM_W    = 10,
  parameter int MIN_BITS = 7,
  parameter int OVS      = 16,
  parameter int CHARS    = 4
) (
  input logic             clk,
  input logic             srst_n,
  input logic             tick16_i,
  input logic             push_i,
  input logic             pop_i,
  input logic [LVL_W-1:0] fifo_level_i,
  input logic [LVL_W-1:0] trig_level_i,
  input logic             enable_i,
  input logic             timeout_o
);
  localparam int MIN_LIM = OVS * CHARS * MIN_BITS;

  logic             live;
  logic [LIM_W-1:0] seen_q;

  assign live = enable_i && (fifo_level_i != '0) && (trig_level_i > LVL_W'(1));

  // Ticks since the last restart, saturating; used as a lower bound on expiry.
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      seen_q <= '0;
    end else if (!live || push_i || pop_i) begin
      seen_q <= '0;
    end else if (tick16_i && (seen_q != '1)) begin
      seen_q <= seen_q + LIM_W'(1);
    end
  end

  a_r4_empty_clears: assert property (@(posedge clk) disable iff (!srst_n)
    (fifo_level_i == '0) |=> !timeout_o);

  a_r5_disable_clears: assert property (@(posedge clk) disable iff (!srst_n)
    !enable_i |=> !timeout_o);

  a_r6_low_trigger_blocks: assert property (@(posedge clk) disable iff (!srst_n)
    (trig_level_i <= LVL_W'(1)) |=> !timeout_o);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!srst_n)
    (timeout_o && pop_i) |=> !timeout_o);

  a_r10_push_ignored: assert property (@(posedge clk) disable iff (!srst_n)
    (timeout_o && !pop_i && live) |=> timeout_o);

  a_r11_rise_on_clean_tick: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(timeout_o) |-> $past(tick16_i && !push_i && !pop_i));

  a_r2_not_early: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(timeout_o) |-> (seen_q >= LIM_W'(MIN_LIM)));
endmodule

bind rxto_timer rxto_timer_chk #(
  .LVL_W    (LVL_W),
  .LIM_W    (LIM_W),
  .MIN_BITS (MIN_BITS),
  .OVS      (OVS),
  .CHARS    (CHARS)
) u_chk (
  .clk          (clk),
  .srst_n       (srst_n),
  .tick16_i     (tick16_i),
  .push_i       (push_i),
  .pop_i        (pop_i),
  .fifo_level_i (fifo_level_i),
  .trig_level_i (trig_level_i),
  .enable_i     (enable_i),
  .timeout_o    (timeout_o)
);

// File: tb/rxto_timer_test.sv
`timescale 1ns/1ps
module rxto_timer_test;
  logic       clk;
  logic       rst_n;
  logic       tick;
  logic [3:0] fbits;
  logic       push;
  logic       pop;
  logic [4:0] level;
  logic [4:0] trig;
  logic       en;
  logic       tout;

  int    n_checks;
  int    n_err;
  int    m_cnt;
  bit    m_flag;
  bit    done;
  string tag;

  rxto_timer uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick16_i     (tick),
    .frame_bits_i (fbits),
    .push_i       (push),
    .pop_i        (pop),
    .fifo_level_i (level),
    .trig_level_i (trig),
    .enable_i     (en),
    .timeout_o    (tout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int limit_of(int fb);
    int b;
    b = (fb < 7) ? 7 : ((fb > 12) ? 12 : fb);
    return 64 * b;
  endfunction

  task automatic check_out();
    n_checks++;
    if (tout !== m_flag) begin
      n_err++;
      $display("FAIL %s: timeout=%0b expected %0b (t=%0t)", tag, tout, m_flag, $time);
    end
  endtask

  // Drive one cycle, advance the reference model, then compare after the edge.
  task automatic step(bit tk, bit pu, bit po);
    bit armed;
    tick = tk;
    push = pu;
    pop  = po;
    armed = en && (level != 0) && (trig > 1) && rst_n;
    if (!armed) begin
      m_cnt = 0;
      m_flag = 0;
    end else if (m_flag) begin
      if (po) begin
        m_flag = 0;
        m_cnt = 0;
      end
    end else if (pu || po) begin
      m_cnt = 0;
    end else if (tk) begin
      m_cnt++;
      if (m_cnt == limit_of(int'(fbits))) begin
        m_flag = 1;
        m_cnt = 0;
      end
    end
    @(posedge clk);
    #5;
    check_out();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 190000);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    n_checks = 0; n_err = 0; m_cnt = 0; m_flag = 0; done = 0;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; tick = 0; push = 0; pop = 0;
    fbits = 4'd12; level = 5'd0; trig = 5'd4; en = 1'b0;

    tag = "R1";
    #3;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0);

    // R2: exact expiry at 768 ticks for a 12-bit frame
    tag = "R2"; en = 1'b1; level = 5'd3; trig = 5'd4; fbits = 4'd12;
    run(767);
    run(1);
    // R10: pushes while pending leave the flag set
    tag = "R10";
    step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    run(20);
    // R9: one read clears and restarts
    tag = "R9";
    step(1'b0, 1'b0, 1'b1);
    run(768);
    step(1'b1, 1'b0, 1'b1);
    // R8: read restarts the count while low
    tag = "R8";
    run(500);
    step(1'b1, 1'b0, 1'b1);
    run(768);
    step(1'b0, 1'b0, 1'b1);
    // R7: push restarts the count while low
    tag = "R7";
    run(400);
    step(1'b0, 1'b1, 1'b0);
    run(768);
    step(1'b0, 1'b0, 1'b1);
    // R11: tick in a restart cycle is not counted
    tag = "R11";
    run(300);
    step(1'b1, 1'b1, 1'b0);
    run(767);
    run(1);
    step(1'b0, 1'b0, 1'b1);
    // R3: clamping of out-of-range frame lengths
    tag = "R3"; fbits = 4'd3;
    run(448);
    step(1'b0, 1'b0, 1'b1);
    fbits = 4'd15;
    run(768);
    step(1'b0, 1'b0, 1'b1);
    fbits = 4'd7;
    run(448);
    step(1'b0, 1'b0, 1'b1);
    // R4: empty FIFO clears the flag and the count
    tag = "R4"; fbits = 4'd8;
    run(512);
    level = 5'd0; step(1'b1, 1'b0, 1'b0);
    level = 5'd2; run(300);
    level = 5'd0; step(1'b1, 1'b0, 1'b0);
    level = 5'd2; run(512);
    // R5: disable clears the flag and the count
    tag = "R5";
    en = 1'b0; step(1'b1, 1'b0, 1'b0);
    en = 1'b1; run(400);
    en = 1'b0; step(1'b1, 1'b0, 1'b0);
    en = 1'b1; run(512);
    // R6: trigger level of one or zero suppresses the timer
    tag = "R6";
    trig = 5'd1; run(1200);
    trig = 5'd0; run(600);
    trig = 5'd2; run(512);
    step(1'b0, 1'b0, 1'b1);

    // Random phase: spaced ticks, varied frame and qualifiers, rare restarts
    tag = "R2";
    for (int i = 0; i < 60000; i++) begin
      if ((i % 2500) == 0) begin
        fbits = 4'($urandom % 16);
        trig  = ($urandom % 8 == 0) ? 5'd1 : 5'(2 + $urandom % 14);
        en    = ($urandom % 10) != 0;
      end
      if ((i % 700) == 0) level = ($urandom % 6 == 0) ? 5'd0 : 5'(1 + $urandom % 16);
      step(($urandom % 4) != 0, ($urandom % 1200) == 0, ($urandom % 1200) == 0);
    end

    finish_run();
  end
endmodule